// File: doc/BRIEF.md
# Serial Frame Receiver Engine

This block recovers character frames from a single serial input line. A frame is a low start bit, five to nine data bits sent least significant bit first, an optional parity bit, and a high stop bit. In asynchronous mode the engine is paced by an oversampling strobe from an external baud generator: it confirms a start bit by re-sampling the line half a bit time later, then samples every following bit at its middle. In synchronous mode it samples the line on each rising edge of an external transfer clock instead.

When the first stop bit has been sampled, the engine delivers the character on `rx_data`, with the ninth bit on `rx_bit8`, the frame and parity error status, and a one-cycle `frame_done` pulse. All of these are held until the next frame completes. A one-cycle `start_det` pulse marks each confirmed start bit, so that buffer logic downstream can detect overrun. The line and the transfer clock pass through `SYNC_STAGES` flip-flops before use. Dropping `rx_en` abandons a frame in progress at once.

Top module: `serial_rx_engine`

## Requirements
- R1: After a synchronous reset, `rx_data`, `rx_bit8`, `frame_err`, `parity_err`, `frame_done` and `start_det` are all 0.
- R2: In asynchronous mode an idle engine that sees the line low on an `os_tick` re-samples it OVS/2 ticks later. If the line is still low, it raises `start_det` for one cycle and starts the frame. If the line is high, the event is dropped: no `start_det` and no frame.
- R3: `bits_sel` selects the data width: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits, and 4 to 7 give 9 bits. Data bits are sampled every OVS ticks after the start midpoint, least significant bit first.
- R4: Bit i of `rx_data` is the i-th received data bit, and every bit at or above the selected width is 0. `rx_bit8` carries the ninth data bit in 9-bit mode and is 0 otherwise.
- R5: With `par_chk`=1, one parity bit follows the data. `parity_err` is 1 when that bit differs from the XOR of the data bits (`par_odd`=0) or from its inverse (`par_odd`=1).
- R6: With `par_chk`=0, no parity bit is expected and `parity_err` is delivered as 0.
- R7: `frame_err` is the inverse of the first stop bit. Any further stop bits are not checked, and a frame with two stop bits is followed cleanly by the next frame.
- R8: `frame_done` is a one-cycle pulse in the cycle after the stop bit is sampled. The delivered outputs change only together with that pulse, and `frame_done` and `start_det` never coincide.
- R9: While `rx_en` is 0 the engine is idle and emits no pulses. A frame that was cut short this way is never delivered, and a frame sent after re-enabling is received correctly.
- R10: With `sync_mode`=1, every bit, the start bit included, is sampled on a rising edge of the synchronized `xclk`. There is no midpoint confirmation, and `os_tick` has no effect.
- R11: Width and parity settings are captured when the start bit is confirmed. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; 0 aborts and idles |
| sync_mode | input | 1 | 0: oversampled asynchronous, 1: external transfer clock |
| bits_sel | input | 3 | Data width code (see R3) |
| par_chk | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| os_tick | input | 1 | Oversampling strobe, OVS per bit time |
| rxd | input | 1 | Serial data line |
| xclk | input | 1 | External transfer clock (synchronous mode) |
| rx_data | output | 8 | Low eight data bits of the last frame |
| rx_bit8 | output | 1 | Ninth data bit of the last frame |
| frame_err | output | 1 | First stop bit was sampled low |
| parity_err | output | 1 | Parity mismatch in the last frame |
| frame_done | output | 1 | One-cycle pulse: outputs updated |
| start_det | output | 1 | One-cycle pulse: start bit confirmed |

## Verification
The hardest cases to reach are the ones that rely on where a line change falls relative to the sampling instants. Examples are a start glitch that must be gone by the midpoint re-sample, a low stop bit that must not look like a fresh start, and a disable that must land between two data-bit samples. The bench therefore drives the line in whole clocks derived from OVS and the tick divider, and makes each glitch and each low stop bit last just longer or just shorter than the half-bit midpoint plus one tick of jitter and the synchronizer delay. A behavioural model in the bench runs the same timing rules from the ports, so every output is compared on every clock. A scoreboard separately checks each delivered character against the frame the bench sent.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  localparam int WORD_W = 9;

  // Width code to number of data bits: 0..3 -> 5..8, anything above -> 9.
  function automatic logic [3:0] width_of(input logic [2:0] sel);
    logic [3:0] w;
    case (sel)
      3'd0:    w = 4'd5;
      3'd1:    w = 4'd6;
      3'd2:    w = 4'd7;
      3'd3:    w = 4'd8;
      default: w = 4'd9;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/serial_rx_line_sync.sv
module serial_rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd_i,
  input  logic xclk_i,
  output logic line_o,
  output logic xrise_o
);

  logic [STAGES-1:0] rx_ff;
  logic [STAGES-1:0] xc_ff;
  logic              xc_prev;

  // Idle line is high; transfer clock resets low.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ff   <= '1;
      xc_ff   <= '0;
      xc_prev <= 1'b0;
    end else begin
      rx_ff[0] <= rxd_i;
      xc_ff[0] <= xclk_i;
      for (int i = 1; i < STAGES; i++) begin
        rx_ff[i] <= rx_ff[i-1];
        xc_ff[i] <= xc_ff[i-1];
      end
      xc_prev <= xc_ff[STAGES-1];
    end
  end

  assign line_o  = rx_ff[STAGES-1];
  assign xrise_o = xc_ff[STAGES-1] & ~xc_prev;

endmodule

// File: rtl/serial_rx_frame_ctrl.sv
module serial_rx_frame_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en,
  input  logic       sync_mode,
  input  logic       os_tick,
  input  logic       line_i,
  input  logic       xrise_i,
  input  logic [2:0] bits_sel,
  input  logic       par_chk,
  input  logic       par_odd,
  output logic       clear_o,
  output logic       shift_o,
  output logic       parbit_o,
  output logic       stop_o,
  output logic       start_det_o,
  output logic [3:0] nbits_o,
  output logic       chk_o,
  output logic       odd_o
);

  localparam int             CW       = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0]  CNT_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0]  CNT_MID  = CW'(OVS / 2 - 1);

  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic          bit_ev;
  logic          confirm;

  always_comb begin
    bit_ev  = sync_mode ? xrise_i : (os_tick && (cnt == CNT_LAST));
    confirm = rx_en && !line_i &&
              (((st == ST_IDLE) && sync_mode && xrise_i) ||
               ((st == ST_START) && os_tick && (cnt == CNT_MID)));
    clear_o  = confirm;
    shift_o  = rx_en && (st == ST_DATA) && bit_ev;
    parbit_o = rx_en && (st == ST_PAR)  && bit_ev;
    stop_o   = rx_en && (st == ST_STOP) && bit_ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      idx         <= '0;
      start_det_o <= 1'b0;
      nbits_o     <= 4'd8;
      chk_o       <= 1'b0;
      odd_o       <= 1'b0;
    end else if (!rx_en) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      idx         <= '0;
      start_det_o <= 1'b0;
    end else begin
      start_det_o <= confirm;
      if (confirm) begin
        st      <= ST_DATA;
        cnt     <= '0;
        idx     <= '0;
        nbits_o <= width_of(bits_sel);
        chk_o   <= par_chk;
        odd_o   <= par_odd;
      end else begin
        unique case (st)
          ST_IDLE: begin
            if (!sync_mode && os_tick && !line_i) begin
              st  <= ST_START;
              cnt <= '0;
            end
          end
          ST_START: begin
            if (os_tick) begin
              if (cnt == CNT_MID) st <= ST_IDLE;  // glitch: line high at midpoint
              else                cnt <= cnt + 1'b1;
            end
          end
          default: begin
            if (!sync_mode && os_tick)
              cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
            if (bit_ev) begin
              unique case (st)
                ST_DATA: begin
                  idx <= idx + 1'b1;
                  if (idx == nbits_o - 4'd1)
                    st <= chk_o ? ST_PAR : ST_STOP;
                end
                ST_PAR:  st <= ST_STOP;
                ST_STOP: st <= ST_IDLE;
                default: st <= ST_IDLE;
              endcase
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/serial_rx_shifter.sv
module serial_rx_shifter
  import serial_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear_i,
  input  logic       shift_i,
  input  logic       parbit_i,
  input  logic       stop_i,
  input  logic       line_i,
  input  logic [3:0] nbits_i,
  input  logic       chk_i,
  input  logic       odd_i,
  output logic [7:0] data_o,
  output logic       bit8_o,
  output logic       ferr_o,
  output logic       perr_o,
  output logic       done_o
);

  logic [WORD_W-1:0] sreg;
  logic              acc;
  logic              perr_q;
  logic [WORD_W-1:0] word;

  // Bits enter at the top; after n shifts the first bit sits at 9-n.
  always_comb word = sreg >> (4'(WORD_W) - nbits_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '0;
      acc    <= 1'b0;
      perr_q <= 1'b0;
      data_o <= '0;
      bit8_o <= 1'b0;
      ferr_o <= 1'b0;
      perr_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= stop_i;
      if (clear_i) begin
        sreg   <= '0;
        acc    <= 1'b0;
        perr_q <= 1'b0;
      end
      if (shift_i) begin
        sreg <= {line_i, sreg[WORD_W-1:1]};
        acc  <= acc ^ line_i;
      end
      if (parbit_i)
        perr_q <= chk_i && (line_i != (acc ^ odd_i));
      if (stop_i) begin
        data_o <= word[7:0];
        bit8_o <= word[8];
        ferr_o <= ~line_i;
        perr_o <= perr_q;
      end
    end
  end

endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine #(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en,
  input  logic       sync_mode,
  input  logic [2:0] bits_sel,
  input  logic       par_chk,
  input  logic       par_odd,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       xclk,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       frame_err,
  output logic       parity_err,
  output logic       frame_done,
  output logic       start_det
);

  logic       line_s;
  logic       xrise_s;
  logic       clear_s;
  logic       shift_s;
  logic       parbit_s;
  logic       stop_s;
  logic [3:0] nbits_lat;
  logic       chk_lat;
  logic       odd_lat;

  serial_rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .rxd_i   (rxd),
    .xclk_i  (xclk),
    .line_o  (line_s),
    .xrise_o (xrise_s)
  );

  serial_rx_frame_ctrl #(.OVS(OVS)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .rx_en       (rx_en),
    .sync_mode   (sync_mode),
    .os_tick     (os_tick),
    .line_i      (line_s),
    .xrise_i     (xrise_s),
    .bits_sel    (bits_sel),
    .par_chk     (par_chk),
    .par_odd     (par_odd),
    .clear_o     (clear_s),
    .shift_o     (shift_s),
    .parbit_o    (parbit_s),
    .stop_o      (stop_s),
    .start_det_o (start_det),
    .nbits_o     (nbits_lat),
    .chk_o       (chk_lat),
    .odd_o       (odd_lat)
  );

  serial_rx_shifter u_shift (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (clear_s),
    .shift_i  (shift_s),
    .parbit_i (parbit_s),
    .stop_i   (stop_s),
    .line_i   (line_s),
    .nbits_i  (nbits_lat),
    .chk_i    (chk_lat),
    .odd_i    (odd_lat),
    .data_o   (rx_data),
    .bit8_o   (rx_bit8),
    .ferr_o   (frame_err),
    .perr_o   (parity_err),
    .done_o   (frame_done)
  );

endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
  input logic       clk,
  input logic       rst,
  input logic       rx_en,
  input logic       frame_done,
  input logic       start_det,
  input logic [7:0] rx_data,
  input logic       rx_bit8,
  input logic       frame_err,
  input logic       parity_err,
  input logic       chk_l,
  input logic [3:0] nbits_l
);

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !start_det);

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_done && nbits_l < 4'd9) |-> (!rx_bit8 && ((rx_data >> nbits_l) == 8'd0)));

  assert_no_parity_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !chk_l) |-> !parity_err);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_done |-> ($stable(rx_data) && $stable(rx_bit8) &&
                     $stable(frame_err) && $stable(parity_err)));

  assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(frame_done && start_det));

  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!frame_done && !start_det));

endmodule

bind serial_rx_engine serial_rx_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .rx_en      (rx_en),
  .frame_done (frame_done),
  .start_det  (start_det),
  .rx_data    (rx_data),
  .rx_bit8    (rx_bit8),
  .frame_err  (frame_err),
  .parity_err (parity_err),
  .chk_l      (chk_lat),
  .nbits_l    (nbits_lat)
);

// File: tb/serial_rx_engine_tb.sv
module serial_rx_engine_tb;

  localparam int OVS  = 8;
  localparam int S    = 2;
  localparam int TDIV = 4;
  localparam int BIT  = OVS * TDIV;
  localparam int XH   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, sync_mode = 1'b0, par_chk = 1'b0, par_odd = 1'b0;
  logic [2:0] bits_sel = 3'd3;
  logic os_tick = 1'b0, rxd = 1'b1, xclk = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit8, frame_err, parity_err, frame_done, start_det;

  int checks = 0, fails = 0, exp_starts = 0, got_starts = 0, done_cnt = 0, tcnt = 0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;  // 125 MHz

  serial_rx_engine #(.OVS(OVS), .SYNC_STAGES(S)) u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .sync_mode(sync_mode), .bits_sel(bits_sel),
    .par_chk(par_chk), .par_odd(par_odd), .os_tick(os_tick), .rxd(rxd), .xclk(xclk),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .frame_err(frame_err), .parity_err(parity_err),
    .frame_done(frame_done), .start_det(start_det)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Oversampling strobe: one clock in TDIV.
  always @(negedge clk) begin
    tcnt    = (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    os_tick = (tcnt == 0);
  end

  // Behavioural reference model (timing rules from the requirements).
  int   m_st = 0, m_cnt = 0, m_idx = 0, m_n = 8;
  logic m_rxq[S], m_xq[S];
  logic m_xprev, m_pchk, m_podd, m_acc, m_perr_q;
  logic [8:0] m_sh, m_word;
  logic [7:0] m_data = 8'd0;
  logic m_bit8 = 1'b0, m_ferr = 1'b0, m_perr = 1'b0, m_done = 1'b0, m_start = 1'b0;

  function automatic int width_code(input logic [2:0] s);
    return (s < 3'd4) ? 5 + int'(s) : 9;
  endfunction

  always @(posedge clk) begin
    logic rxs, xs, xr, ev, conf;
    if (rst) begin
      for (int i = 0; i < S; i++) begin m_rxq[i] = 1'b1; m_xq[i] = 1'b0; end
      m_xprev = 1'b0; m_st = 0; m_cnt = 0; m_idx = 0;
      m_data = 8'd0; m_bit8 = 1'b0; m_ferr = 1'b0; m_perr = 1'b0;
      m_done = 1'b0; m_start = 1'b0; m_sh = 9'd0; m_acc = 1'b0; m_perr_q = 1'b0;
    end else begin
      rxs = m_rxq[S-1]; xs = m_xq[S-1]; xr = xs && !m_xprev;
      for (int i = S - 1; i > 0; i--) begin m_rxq[i] = m_rxq[i-1]; m_xq[i] = m_xq[i-1]; end
      m_rxq[0] = rxd; m_xq[0] = xclk; m_xprev = xs;
      m_done = 1'b0; m_start = 1'b0; conf = 1'b0;
      if (!rx_en) begin
        m_st = 0; m_cnt = 0;
      end else begin
        case (m_st)
          0: if (sync_mode && xr && !rxs) conf = 1'b1;
             else if (!sync_mode && os_tick && !rxs) begin m_st = 1; m_cnt = 0; end
          1: if (os_tick) begin
               if (m_cnt == OVS / 2 - 1) begin
                 if (!rxs) conf = 1'b1; else m_st = 0;
               end else m_cnt++;
             end
          default: begin
            ev = sync_mode ? xr : (os_tick && m_cnt == OVS - 1);
            if (!sync_mode && os_tick) m_cnt = (m_cnt == OVS - 1) ? 0 : m_cnt + 1;
            if (ev) begin
              if (m_st == 2) begin
                m_sh = {rxs, m_sh[8:1]}; m_acc ^= rxs; m_idx++;
                if (m_idx == m_n) m_st = m_pchk ? 3 : 4;
              end else if (m_st == 3) begin
                m_perr_q = m_pchk && (rxs != (m_acc ^ m_podd)); m_st = 4;
              end else begin
                m_word = m_sh >> (9 - m_n);
                m_data = m_word[7:0]; m_bit8 = m_word[8];
                m_ferr = !rxs; m_perr = m_perr_q; m_done = 1'b1; m_st = 0;
              end
            end
          end
        endcase
        if (conf) begin
          m_start = 1'b1; m_st = 2; m_cnt = 0; m_idx = 0; m_sh = 9'd0;
          m_acc = 1'b0; m_perr_q = 1'b0;
          m_n = width_code(bits_sel); m_pchk = par_chk; m_podd = par_odd;
        end
      end
    end
  end

  // Per-cycle model compare and frame scoreboard.
  always @(negedge clk) begin
    logic [11:0] e;
    string t;
    if (!rst) begin
      check({frame_done, start_det, rx_bit8, frame_err, parity_err, rx_data} ==
            {m_done, m_start, m_bit8, m_ferr, m_perr, m_data}, "R8 model",
            {19'd0, frame_done, start_det, rx_bit8, frame_err, parity_err, rx_data},
            {19'd0, m_done, m_start, m_bit8, m_ferr, m_perr, m_data});
      if (start_det) got_starts++;
      if (frame_done) begin
        done_cnt++;
        if (exp_q.size() == 0) check(1'b0, "R9 unexpected frame", {20'd0, rx_data}, 32'd0);
        else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check({parity_err, frame_err, rx_bit8, rx_data} == e, t,
                {20'd0, parity_err, frame_err, rx_bit8, rx_data}, {20'd0, e});
        end
      end
    end
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] pack_exp(input logic [8:0] m, input int n, input bit pen,
                                           input bit badp, input bit stopv);
    return {pen && badp, !stopv, (n == 9) ? m[8] : 1'b0, m[7:0]};
  endfunction

  task automatic send_async(input logic [8:0] val, input int n, input bit pen, input bit podd,
                            input bit badp, input bit stopv, input int nstop, input bit chg,
                            input string tag);
    logic [8:0] m;
    m = val & ((9'h1 << n) - 9'h1);
    sync_mode = 1'b0; par_chk = pen; par_odd = podd;
    bits_sel = (n >= 9) ? 3'd4 : 3'(n - 5);
    exp_q.push_back(pack_exp(m, n, pen, badp, stopv)); tag_q.push_back(tag); exp_starts++;
    rxd = 1'b0; waitc(BIT);
    if (chg) begin bits_sel = 3'd0; par_chk = !pen; end  // R11: ignored mid-frame
    for (int i = 0; i < n; i++) begin rxd = m[i]; waitc(BIT); end
    if (pen) begin rxd = (^m) ^ podd ^ badp; waitc(BIT); end
    if (stopv) begin rxd = 1'b1; waitc(BIT * nstop); end
    else begin rxd = 1'b0; waitc(BIT / 2 + TDIV + 4); rxd = 1'b1; waitc(BIT * nstop); end
    waitc(BIT);
  endtask

  task automatic xbit(input logic b);
    xclk = 1'b0; rxd = b; waitc(XH); xclk = 1'b1; waitc(XH);
  endtask

  task automatic send_sync(input logic [8:0] val, input int n, input bit pen, input bit podd,
                           input bit badp, input string tag);
    logic [8:0] m;
    m = val & ((9'h1 << n) - 9'h1);
    sync_mode = 1'b1; par_chk = pen; par_odd = podd;
    bits_sel = (n >= 9) ? 3'd4 : 3'(n - 5);
    xbit(1'b1); xbit(1'b1);
    exp_q.push_back(pack_exp(m, n, pen, badp, 1'b1)); tag_q.push_back(tag); exp_starts++;
    xbit(1'b0);
    for (int i = 0; i < n; i++) xbit(m[i]);
    if (pen) xbit((^m) ^ podd ^ badp);
    xbit(1'b1); xbit(1'b1); xbit(1'b1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int s0, d0;
    waitc(6);
    rst = 1'b0;
    waitc(1);
    // R1: reset state
    check(rx_data == 8'd0, "R1 rx_data", {24'd0, rx_data}, 32'd0);
    check(!rx_bit8, "R1 rx_bit8", {31'd0, rx_bit8}, 32'd0);
    check(!frame_err, "R1 frame_err", {31'd0, frame_err}, 32'd0);
    check(!parity_err, "R1 parity_err", {31'd0, parity_err}, 32'd0);
    check(!frame_done && !start_det, "R1 pulses", {30'd0, frame_done, start_det}, 32'd0);
    rx_en = 1'b1;
    waitc(BIT);

    send_async(9'h0A5, 8, 0, 0, 0, 1, 1, 0, "R3 8-bit A5");
    send_async(9'h05A, 8, 0, 0, 0, 1, 1, 0, "R3 8-bit 5A");
    send_async(9'h1FB, 5, 0, 0, 0, 1, 1, 0, "R4 5-bit upper zero");
    send_async(9'h0FF, 6, 0, 0, 0, 1, 1, 0, "R4 6-bit");
    send_async(9'h155, 7, 0, 0, 0, 1, 1, 0, "R4 7-bit");
    send_async(9'h1C3, 9, 0, 0, 0, 1, 1, 0, "R4 9-bit bit8 set");
    send_async(9'h03C, 9, 0, 0, 0, 1, 1, 0, "R3 9-bit bit8 clear");
    send_async(9'h0B7, 8, 1, 0, 0, 1, 1, 0, "R5 even ok");
    send_async(9'h0B7, 8, 1, 0, 1, 1, 1, 0, "R5 even bad");
    send_async(9'h013, 7, 1, 1, 0, 1, 1, 0, "R5 odd ok");
    send_async(9'h013, 7, 1, 1, 1, 1, 1, 0, "R5 odd bad");
    send_async(9'h0C4, 8, 0, 1, 0, 1, 1, 0, "R6 parity off");
    send_async(9'h066, 8, 0, 0, 0, 0, 1, 0, "R7 low stop");
    send_async(9'h099, 8, 1, 0, 0, 1, 2, 0, "R7 two stops");
    send_async(9'h011, 8, 0, 0, 0, 1, 1, 0, "R7 after two stops");
    send_async(9'h0E1, 8, 0, 0, 0, 1, 1, 1, "R11 config latched");

    // R2: glitch shorter than half a bit
    s0 = got_starts; d0 = done_cnt;
    rxd = 1'b0; waitc(2 * TDIV); rxd = 1'b1; waitc(2 * BIT);
    check(got_starts == s0, "R2 glitch no start", got_starts, s0);
    check(done_cnt == d0, "R2 glitch no frame", done_cnt, d0);

    // R9: abort mid-frame
    bits_sel = 3'd3; par_chk = 1'b0; sync_mode = 1'b0;
    d0 = done_cnt;
    rxd = 1'b0; waitc(BIT); rxd = 1'b1; waitc(BIT); rxd = 1'b0; waitc(BIT);
    exp_starts++;
    rx_en = 1'b0; waitc(10); rxd = 1'b1; waitc(BIT * 12);
    check(done_cnt == d0, "R9 aborted frame dropped", done_cnt, d0);
    check(!frame_done && !start_det, "R9 quiet", {30'd0, frame_done, start_det}, 32'd0);
    rx_en = 1'b1; waitc(BIT);
    send_async(9'h03D, 8, 0, 0, 0, 1, 1, 0, "R9 frame after re-enable");

    // R10: synchronous mode
    send_sync(9'h0A3, 8, 0, 0, 0, "R10 sync 8-bit");
    send_sync(9'h12D, 9, 1, 1, 0, "R10 sync 9-bit odd ok");
    send_sync(9'h00E, 5, 1, 0, 1, "R10 sync 5-bit even bad");
    xbit(1'b1); xbit(1'b1);
    sync_mode = 1'b0; waitc(BIT);

    check(exp_q.size() == 0, "R8 all frames delivered", exp_q.size(), 0);
    check(got_starts == exp_starts, "R2 start pulse count", got_starts, exp_starts);
    finish_run();
  end

endmodule